// File: doc/BRIEF.md
# Comparison Specification Register File

This block keeps a small set of comparison specifications for an in-order pipeline. A specification names the operands of a later compare-and-branch, not their values. It is either two general-purpose register numbers, or one register number and a small unsigned constant. A compare-spec instruction in decode writes a 16-bit specification into one entry. The entry is committed at the clock edge that ends its decode cycle. A compare-and-branch in decode picks an entry with a 4-bit selector. The block returns the extracted fields combinationally within the same cycle, so the second half of decode can address the general-purpose register file with them.

The block stores register numbers and no data, so a write never waits on a data producer. When a compare-spec and a compare-and-branch that name the same entry are both in decode in one cycle, the new specification is forwarded straight to the read outputs and the branch does not stall. Each stored pattern is presented both ways at once: as a second register number and as a 12-bit constant. The consuming branch chooses which of the two it uses. A constant from 0 to 15 therefore has the same bit pattern as the register number of the same value.

Top module: `cspec_regfile`

## Requirements
- R1: After synchronous active-high reset, every one of the 16 entries reads as all zeros.
- R2: With wr_en high, wr_spec is stored into entry wr_sel at the clock edge and is returned by any later read of that entry until that entry is written again.
- R3: rs1_idx equals bits 15..12 of the selected specification.
- R4: rs2_idx equals bits 3..0 of the selected specification; bits 11..4 have no effect on it.
- R5: imm12 equals bits 11..0 of the selected specification, read as an unsigned constant.
- R6: In every cycle rs2_idx equals imm12[3..0], so a single stored entry serves both a register compare and a constant compare.
- R7: When wr_en and rd_en are both high and wr_sel equals rd_sel, the outputs come from wr_spec in that same cycle, taking priority over the stored entry.
- R8: A write to an entry other than rd_sel in the same cycle does not change the read outputs.
- R9: rd_valid follows rd_en; while rd_en is low, rs1_idx, rs2_idx and imm12 are all zero.
- R10: With wr_en low, no entry changes, whatever wr_sel and wr_spec hold.
- R11: Writes to the same entry in consecutive cycles leave the last one stored, and each one is forwarded to a read of that entry in its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A compare-spec is in decode this cycle |
| wr_sel | input | 4 | Entry written by the compare-spec |
| wr_spec | input | 16 | Specification to store |
| rd_en | input | 1 | A compare-and-branch is in decode this cycle |
| rd_sel | input | 4 | Entry read by the compare-and-branch |
| rs1_idx | output | 4 | First general-purpose register number |
| rs2_idx | output | 4 | Second general-purpose register number |
| imm12 | output | 12 | Same tail read as an unsigned constant |
| rd_valid | output | 1 | Read outputs are meaningful |

## Verification
The bench aims at the same-cycle collision of write and read on one entry. A design that omitted or mis-prioritised the bypass would return the stale entry there, and one that compared the wrong selector bits would forward into unrelated reads. It writes tails with bits 11..4 set, which exposes a rs2_idx taken from the wrong slice, and it checks writes with wr_en low and writes to a neighbouring entry for any leak. Back-to-back writes to one entry and a read of every entry after reset catch lost updates and reset values other than zero.

// File: rtl/cspec_pkg.sv
package cspec_pkg;
    localparam int unsigned N_ENTRIES = 16;
    localparam int unsigned SEL_W     = $clog2(N_ENTRIES);
    localparam int unsigned GPR_W     = 4;
    localparam int unsigned TAIL_W    = 12;
    localparam int unsigned SPEC_W    = GPR_W + TAIL_W;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [GPR_W-1:0]  gpr_t;

    typedef struct packed {
        gpr_t              first;
        logic [TAIL_W-1:0] tail;
    } spec_t;

    typedef struct packed {
        gpr_t              rs1;
        gpr_t              rs2;
        logic [TAIL_W-1:0] imm;
        logic              valid;
    } fields_t;

    function automatic fields_t split_spec(input spec_t s, input logic en);
        fields_t f;
        f.rs1   = en ? s.first : '0;
        f.rs2   = en ? s.tail[GPR_W-1:0] : '0;
        f.imm   = en ? s.tail : '0;
        f.valid = en;
        return f;
    endfunction
endpackage

// File: rtl/cspec_store.sv
module cspec_store
    import cspec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  sel_t  wsel,
    input  spec_t wdata,
    input  sel_t  rsel,
    output spec_t rdata
);
    spec_t entry [N_ENTRIES];

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[i] <= '0;
            else if (we && wsel == sel_t'(i))
                entry[i] <= wdata;
        end
    end

    assign rdata = entry[rsel];
endmodule

// File: rtl/cspec_bypass.sv
module cspec_bypass
    import cspec_pkg::*;
(
    input  logic  we,
    input  sel_t  wsel,
    input  spec_t wdata,
    input  logic  re,
    input  sel_t  rsel,
    input  spec_t stored,
    output spec_t chosen
);
    logic hit;
    always_comb begin
        hit    = we && re && (wsel == rsel);
        chosen = hit ? wdata : stored;
    end
endmodule

// File: rtl/cspec_fields.sv
module cspec_fields
    import cspec_pkg::*;
(
    input  logic    re,
    input  spec_t   spec,
    output fields_t f
);
    always_comb f = split_spec(spec, re);
endmodule

// File: rtl/cspec_regfile.sv
module cspec_regfile
    import cspec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_sel,
    input  logic [15:0] wr_spec,
    input  logic        rd_en,
    input  logic [3:0]  rd_sel,
    output logic [3:0]  rs1_idx,
    output logic [3:0]  rs2_idx,
    output logic [11:0] imm12,
    output logic        rd_valid
);
    spec_t   stored_q;
    spec_t   chosen;
    fields_t f;

    cspec_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .wsel  (wr_sel),
        .wdata (spec_t'(wr_spec)),
        .rsel  (rd_sel),
        .rdata (stored_q)
    );

    cspec_bypass u_byp (
        .we     (wr_en),
        .wsel   (wr_sel),
        .wdata  (spec_t'(wr_spec)),
        .re     (rd_en),
        .rsel   (rd_sel),
        .stored (stored_q),
        .chosen (chosen)
    );

    cspec_fields u_fields (
        .re   (rd_en),
        .spec (chosen),
        .f    (f)
    );

    assign rs1_idx  = f.rs1;
    assign rs2_idx  = f.rs2;
    assign imm12    = f.imm;
    assign rd_valid = f.valid;
endmodule

// File: rtl/cspec_regfile_chk.sv
module cspec_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  wr_sel,
    input logic [15:0] wr_spec,
    input logic        rd_en,
    input logic [3:0]  rd_sel,
    input logic [3:0]  rs1_idx,
    input logic [3:0]  rs2_idx,
    input logic [11:0] imm12,
    input logic        rd_valid
);
    logic fwd;
    assign fwd = wr_en && rd_en && (wr_sel == rd_sel);

    a_r7_forward: assert property (@(posedge clk) disable iff (rst)
        fwd |-> ({rs1_idx, imm12} == wr_spec));

    a_r2_stored_next: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !fwd && !$past(rst) && $past(wr_en) && $past(wr_sel) == rd_sel)
        |-> ({rs1_idx, imm12} == $past(wr_spec)));

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_en && !fwd) |-> ({rs1_idx, imm12} == 16'h0));

    a_r6_shared_low: assert property (@(posedge clk) disable iff (rst)
        rs2_idx == imm12[3:0]);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (!rd_valid && rs1_idx == 4'h0 && imm12 == 12'h0));
endmodule

bind cspec_regfile cspec_regfile_chk u_chk (.*);

// File: tb/tb_cspec_regfile.sv
module tb_cspec_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_spec = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_sel = '0;
    logic [3:0]  rs1_idx, rs2_idx;
    logic [11:0] imm12;
    logic        rd_valid;

    always #4 clk = ~clk;   // 125 MHz

    cspec_regfile dut (.*);

    typedef struct {
        logic [3:0]  rs1;
        logic [3:0]  rs2;
        logic [11:0] imm;
        logic        vld;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mdl [16];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    // driver: one cycle per call; expected value derived from the requirements
    task automatic step(input logic we, input logic [3:0] ws, input logic [15:0] wd,
                        input logic re, input logic [3:0] rs, input string req);
        exp_t        e;
        logic [15:0] s;
        @(posedge clk);
        #1;
        wr_en = we; wr_sel = ws; wr_spec = wd; rd_en = re; rd_sel = rs;
        s     = (we && re && ws == rs) ? wd : mdl[rs];
        e.rs1 = re ? s[15:12] : 4'h0;
        e.rs2 = re ? s[3:0]   : 4'h0;
        e.imm = re ? s[11:0]  : 12'h0;
        e.vld = re;
        e.req = req;
        sb.push_back(e);
        if (we) mdl[ws] = wd;
    endtask

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if ({rs1_idx, rs2_idx, imm12, rd_valid} !== {e.rs1, e.rs2, e.imm, e.vld}) begin
                n_bad++;
                $display("FAIL %s: got rs1=%h rs2=%h imm=%h v=%b exp rs1=%h rs2=%h imm=%h v=%b",
                         e.req, rs1_idx, rs2_idx, imm12, rd_valid, e.rs1, e.rs2, e.imm, e.vld);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: all entries zero after reset
        for (int i = 0; i < 16; i++) step(1'b0, 4'h0, 16'h0, 1'b1, 4'(i), "R1");
        // R9: idle read gives zeros and rd_valid low
        step(1'b0, 4'h0, 16'h0, 1'b0, 4'h0, "R9");
        // R2/R3/R4/R5: store then read; bits 11..4 set to expose slicing
        step(1'b1, 4'h3, 16'h7AB5, 1'b0, 4'h0, "R2");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'h3, "R2 R3 R4 R5");
        step(1'b1, 4'hF, 16'hC00D, 1'b0, 4'h0, "R2");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'hF, "R3 R5 R6");
        // R7: same-cycle forward over the stored value
        step(1'b1, 4'h3, 16'h1FF8, 1'b1, 4'h3, "R7");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'h3, "R2 after R7");
        // R8: write to a neighbour does not change the read
        step(1'b1, 4'h2, 16'hEEEE, 1'b1, 4'h3, "R8");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'h2, "R8 neighbour stored");
        // R10: wr_en low ignored
        step(1'b0, 4'h3, 16'hFFFF, 1'b1, 4'h3, "R10");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'h3, "R10 entry kept");
        // R11: consecutive writes, each forwarded, last wins
        step(1'b1, 4'h9, 16'h1234, 1'b1, 4'h9, "R11");
        step(1'b1, 4'h9, 16'h5678, 1'b1, 4'h9, "R11");
        step(1'b1, 4'h9, 16'h9ABC, 1'b1, 4'h9, "R11");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'h9, "R11 last wins");
        // R9: idle while a write hits the same selector
        step(1'b1, 4'h5, 16'hA5A5, 1'b0, 4'h5, "R9");
        step(1'b0, 4'h0, 16'h0, 1'b1, 4'h5, "R6 R2");
        // R6: small constant shares the register-number pattern
        step(1'b1, 4'h0, 16'h2008, 1'b1, 4'h0, "R6");
        @(posedge clk);
        @(negedge clk);
        #1 done = 1'b1;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
        end
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule